// File: doc/BRIEF.md
# Trap Entry Sequencer

This block carries out the state change a processor core makes when it takes a trap, and the reverse change when it returns from one. The core presents its live condition codes, address-space identifier, processor-state word, window pointer, PC, next-PC and a trap type. On an accepted trap the sequencer pushes all of them onto per-level stacks and raises the trap level. It then emits a one-cycle update bundle that holds the forced processor state, the adjusted window pointer and the handler PC and next-PC, which it derives from a base address. A return request pops the current level and emits the saved values.

The trap request is a valid/ready stream. `trap_ready` is the only back-pressure point: it stays high until the block enters error mode, and from then until reset no request is taken. The update bundle is a plain one-cycle pulse on `upd_valid` with no back-pressure, so the core must apply it in the cycle it appears. A small combinational checker also flags misaligned data accesses, which the core turns into trap type 0x034.

Top module: `trap_entry_seq`

## Requirements
- R1: After reset `trap_lvl` is 0, `err_mode` is 0, `upd_valid` is 0, `trap_ready` is 1 and `saved_type` is 0.
- R2: A trap accepted at level L < MAX_LVL sets `trap_lvl` to L+1. In the cycle after acceptance it pulses `upd_valid` with `upd_ret`=0, and `upd_cc` and `upd_sid` equal the presented `cur_cc` and `cur_sid`.
- R3: The processor-state word has these bits: [9:8] memory model, [7] recovery, [6] FPU enable, [5] address mask, [4] privileged, [3] interrupt enable, [2] alternate globals, [1] current little-endian, [0] trap little-endian. On entry `upd_ps` takes these values:
  - privileged = 1, alternate globals = 1
  - interrupt enable = 0, address mask = 0, recovery = 0
  - FPU enable = HAS_FPU
  - memory model and trap little-endian are unchanged
  - current little-endian is loaded from trap little-endian.
- R4: Trap type 0x024 gives `upd_win` = `cur_win`+1 modulo NWIN.
- R5: Trap types 0x080 to 0x0BF give `upd_win` = `cur_win`+`save_avail`+2 modulo NWIN.
- R6: Trap types 0x0C0 to 0x0FF give `upd_win` = `cur_win`-1 modulo NWIN. Every other type leaves `upd_win` = `cur_win`.
- R7: On entry `upd_pc` = {`base_addr`[VA-1:15], L!=0, `trap_type`[8:0], 5'b00000}, where L is the level before the trap. `upd_npc` is the same value with its low five bits equal to 5'b00100.
- R8: While `trap_lvl` is above 0, `saved_type` shows the trap type recorded for the current level.
- R9: A return at level L > 0 emits `upd_valid` with `upd_ret`=1 and the cc, sid, ps, win, pc and npc saved at level L, then sets `trap_lvl` to L-1. A return at level 0 has no effect.
- R10: A trap accepted at level MAX_LVL pushes nothing and leaves the level unchanged. It sets `err_mode`, which stays set until reset, and while `err_mode` is set `trap_ready` is 0 and returns have no effect.
- R11: When a trap is accepted in the same cycle as a return request, the trap is taken and the return is dropped.
- R12: `misalign` is 1 when the low address bits are not a multiple of the access size. `acc_size` codes 0, 1, 2, 3 and 4 mean 1, 2, 4, 8 and 16 bytes, and codes 5 to 7 are treated as 16 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_valid | input | 1 | Trap request valid |
| trap_ready | output | 1 | Trap request can be taken |
| trap_type | input | 9 | Trap type of the request |
| base_addr | input | VA | Handler table base address |
| cur_pc | input | VA | Live PC |
| cur_npc | input | VA | Live next-PC |
| cur_cc | input | 8 | Live condition codes |
| cur_sid | input | 8 | Live address-space identifier |
| cur_ps | input | 10 | Live processor-state word |
| cur_win | input | log2(NWIN) | Live window pointer |
| save_avail | input | log2(NWIN) | Savable-windows count |
| ret_valid | input | 1 | Return-from-trap request |
| upd_valid | output | 1 | Update bundle valid (one cycle) |
| upd_ret | output | 1 | Bundle comes from a return (1) or an entry (0) |
| upd_cc | output | 8 | Condition codes to load |
| upd_sid | output | 8 | Address-space identifier to load |
| upd_ps | output | 10 | Processor-state word to load |
| upd_win | output | log2(NWIN) | Window pointer to load |
| upd_pc | output | VA | PC to load |
| upd_npc | output | VA | Next-PC to load |
| trap_lvl | output | log2(MAX_LVL+1) | Current trap level |
| saved_type | output | 9 | Trap type of the current level |
| err_mode | output | 1 | Error mode (trap at maximum level) |
| acc_addr_lo | input | 4 | Low address bits of a data access |
| acc_size | input | 3 | Access size code |
| misalign | output | 1 | Access is misaligned |

## Verification
Error mode is the hardest state to reach from the ports: it needs MAX_LVL traps accepted in a row with no return between them, and then one more. The bench builds that nest one trap at a time. It uses a distinct type and PC at each level, so the level-above-zero vector bit and the stored records can be checked on the way up. It then unwinds the nest, comparing each popped record, and builds the nest again to reach the overflowing trap. The window-pointer wrap cases of the clean, spill and fill ranges are driven from a vector table at both ends of each range.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;
  localparam int TT_W  = 9;
  localparam int PS_W  = 10;
  localparam int CC_W  = 8;
  localparam int SID_W = 8;

  typedef struct packed {
    logic [1:0] mem_model;
    logic       recov;
    logic       fpu_en;
    logic       addr_mask;
    logic       priv;
    logic       int_en;
    logic       alt_glob;
    logic       cur_le;
    logic       trap_le;
  } proc_state_t;

  typedef enum logic [1:0] {WIN_KEEP, WIN_CLEAN, WIN_SPILL, WIN_FILL} win_kind_t;

  localparam logic [TT_W-1:0] TT_CLEAN    = 9'h024;
  localparam logic [TT_W-1:0] TT_SPILL_LO = 9'h080;
  localparam logic [TT_W-1:0] TT_SPILL_HI = 9'h0BF;
  localparam logic [TT_W-1:0] TT_FILL_LO  = 9'h0C0;
  localparam logic [TT_W-1:0] TT_FILL_HI  = 9'h0FF;

  function automatic win_kind_t classify(input logic [TT_W-1:0] tt);
    if (tt == TT_CLEAN) return WIN_CLEAN;
    if (tt >= TT_SPILL_LO && tt <= TT_SPILL_HI) return WIN_SPILL;
    if (tt >= TT_FILL_LO && tt <= TT_FILL_HI) return WIN_FILL;
    return WIN_KEEP;
  endfunction

  function automatic proc_state_t force_entry(input proc_state_t in_ps, input logic has_fpu);
    proc_state_t o;
    o           = in_ps;
    o.recov     = 1'b0;
    o.fpu_en    = has_fpu;
    o.addr_mask = 1'b0;
    o.priv      = 1'b1;
    o.int_en    = 1'b0;
    o.alt_glob  = 1'b1;
    o.cur_le    = in_ps.trap_le;
    return o;
  endfunction
endpackage

// File: rtl/win_adjust.sv
module win_adjust
  import trap_seq_pkg::*;
#(
  parameter int WPW = 3
) (
  input  logic [TT_W-1:0] tt,
  input  logic [WPW-1:0]  win_in,
  input  logic [WPW-1:0]  save_avail,
  output logic [WPW-1:0]  win_out
);
  win_kind_t kind;
  assign kind = classify(tt);

  always_comb begin
    unique case (kind)
      WIN_CLEAN: win_out = win_in + WPW'(1);
      WIN_SPILL: win_out = win_in + save_avail + WPW'(2);
      WIN_FILL:  win_out = win_in - WPW'(1);
      default:   win_out = win_in;
    endcase
  end
endmodule

// File: rtl/vector_gen.sv
module vector_gen
  import trap_seq_pkg::*;
#(
  parameter int VA = 64
) (
  input  logic [VA-1:0]   base,
  input  logic            lvl_nz,
  input  logic [TT_W-1:0] tt,
  output logic [VA-1:0]   pc,
  output logic [VA-1:0]   npc
);
  logic unused_base_lo;
  assign unused_base_lo = ^base[14:0];

  assign pc  = {base[VA-1:15], lvl_nz, tt, 5'b00000};
  assign npc = {base[VA-1:15], lvl_nz, tt, 5'b00100};
endmodule

// File: rtl/align_check.sv
module align_check (
  input  logic [3:0] addr_lo,
  input  logic [2:0] size,
  output logic       fault
);
  logic [3:0] mask;
  always_comb begin
    case (size)
      3'd0:    mask = 4'b0000;
      3'd1:    mask = 4'b0001;
      3'd2:    mask = 4'b0011;
      3'd3:    mask = 4'b0111;
      default: mask = 4'b1111;
    endcase
  end
  assign fault = |(addr_lo & mask);
endmodule

// File: rtl/trap_slot_stack.sv
module trap_slot_stack #(
  parameter int DEPTH = 5,
  parameter int W     = 8,
  parameter int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [W-1:0]  wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [W-1:0]  rd_data
);
  logic [DEPTH-1:0][W-1:0] slot_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          slot_q[g] <= '0;
      else if (wr_en && wr_idx == IW'(g))  slot_q[g] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < DEPTH; i++)
      if (rd_idx == IW'(i)) rd_data = slot_q[i];
  end
endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
  import trap_seq_pkg::*;
#(
  parameter int VA      = 64,
  parameter int NWIN    = 8,
  parameter int MAX_LVL = 5,
  parameter bit HAS_FPU = 1'b1,
  parameter int WPW     = $clog2(NWIN),
  parameter int TLW     = $clog2(MAX_LVL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trap_valid,
  output logic              trap_ready,
  input  logic [TT_W-1:0]   trap_type,
  input  logic [VA-1:0]     base_addr,
  input  logic [VA-1:0]     cur_pc,
  input  logic [VA-1:0]     cur_npc,
  input  logic [CC_W-1:0]   cur_cc,
  input  logic [SID_W-1:0]  cur_sid,
  input  logic [PS_W-1:0]   cur_ps,
  input  logic [WPW-1:0]    cur_win,
  input  logic [WPW-1:0]    save_avail,
  input  logic              ret_valid,
  output logic              upd_valid,
  output logic              upd_ret,
  output logic [CC_W-1:0]   upd_cc,
  output logic [SID_W-1:0]  upd_sid,
  output logic [PS_W-1:0]   upd_ps,
  output logic [WPW-1:0]    upd_win,
  output logic [VA-1:0]     upd_pc,
  output logic [VA-1:0]     upd_npc,
  output logic [TLW-1:0]    trap_lvl,
  output logic [TT_W-1:0]   saved_type,
  output logic              err_mode,
  input  logic [3:0]        acc_addr_lo,
  input  logic [2:0]        acc_size,
  output logic              misalign
);
  localparam int IW   = (MAX_LVL > 1) ? $clog2(MAX_LVL) : 1;
  localparam int ST_W = CC_W + SID_W + PS_W + WPW;
  localparam logic [TLW-1:0] LVL_TOP = TLW'(MAX_LVL);

  logic [TLW-1:0] lvl_q;
  logic           err_q;
  logic           take_trap, push, to_err, pop;
  logic [IW-1:0]  wr_idx, rd_idx;

  assign trap_ready = !err_q;
  assign take_trap  = trap_valid && trap_ready;
  assign push       = take_trap && (lvl_q < LVL_TOP);
  assign to_err     = take_trap && (lvl_q == LVL_TOP);
  assign pop        = ret_valid && !take_trap && !err_q && (lvl_q != '0);
  assign wr_idx     = IW'(lvl_q);
  assign rd_idx     = IW'(lvl_q - TLW'(1));

  // entry-side datapath
  logic [WPW-1:0] adj_win;
  logic [VA-1:0]  vec_pc, vec_npc;
  proc_state_t    forced_ps;

  win_adjust #(.WPW(WPW)) u_win (
    .tt(trap_type), .win_in(cur_win), .save_avail(save_avail), .win_out(adj_win)
  );

  vector_gen #(.VA(VA)) u_vec (
    .base(base_addr), .lvl_nz(lvl_q != '0), .tt(trap_type), .pc(vec_pc), .npc(vec_npc)
  );

  assign forced_ps = force_entry(proc_state_t'(cur_ps), HAS_FPU);

  // per-level stacks
  logic [ST_W-1:0]   st_rd;
  logic [2*VA-1:0]   pcs_rd;
  logic [TT_W-1:0]   tt_rd;

  trap_slot_stack #(.DEPTH(MAX_LVL), .W(ST_W), .IW(IW)) u_st_stack (
    .clk(clk), .rst_n(rst_n), .wr_en(push), .wr_idx(wr_idx),
    .wr_data({cur_cc, cur_sid, cur_ps, cur_win}), .rd_idx(rd_idx), .rd_data(st_rd)
  );

  trap_slot_stack #(.DEPTH(MAX_LVL), .W(2*VA), .IW(IW)) u_pc_stack (
    .clk(clk), .rst_n(rst_n), .wr_en(push), .wr_idx(wr_idx),
    .wr_data({cur_pc, cur_npc}), .rd_idx(rd_idx), .rd_data(pcs_rd)
  );

  trap_slot_stack #(.DEPTH(MAX_LVL), .W(TT_W), .IW(IW)) u_tt_stack (
    .clk(clk), .rst_n(rst_n), .wr_en(push), .wr_idx(wr_idx),
    .wr_data(trap_type), .rd_idx(rd_idx), .rd_data(tt_rd)
  );

  // level and error state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (push)      lvl_q <= lvl_q + TLW'(1);
      else if (pop)  lvl_q <= lvl_q - TLW'(1);
      if (to_err)    err_q <= 1'b1;
    end
  end

  // registered update bundle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_valid <= 1'b0;
      upd_ret   <= 1'b0;
      upd_cc    <= '0;
      upd_sid   <= '0;
      upd_ps    <= '0;
      upd_win   <= '0;
      upd_pc    <= '0;
      upd_npc   <= '0;
    end else if (push) begin
      upd_valid <= 1'b1;
      upd_ret   <= 1'b0;
      upd_cc    <= cur_cc;
      upd_sid   <= cur_sid;
      upd_ps    <= forced_ps;
      upd_win   <= adj_win;
      upd_pc    <= vec_pc;
      upd_npc   <= vec_npc;
    end else if (pop) begin
      upd_valid <= 1'b1;
      upd_ret   <= 1'b1;
      {upd_cc, upd_sid, upd_ps, upd_win} <= st_rd;
      {upd_pc, upd_npc} <= pcs_rd;
    end else begin
      upd_valid <= 1'b0;
    end
  end

  assign trap_lvl   = lvl_q;
  assign err_mode   = err_q;
  assign saved_type = (lvl_q == '0) ? '0 : tt_rd;

  align_check u_align (.addr_lo(acc_addr_lo), .size(acc_size), .fault(misalign));

  // assertions
  p_lvl_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    trap_lvl <= LVL_TOP);

  p_entry_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && trap_ready && trap_lvl < LVL_TOP)
      |=> (trap_lvl == TLW'($past(trap_lvl) + TLW'(1))) && upd_valid && !upd_ret);

  p_ret_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !trap_valid && !err_mode && trap_lvl != '0)
      |=> (trap_lvl == TLW'($past(trap_lvl) - TLW'(1))) && upd_valid && upd_ret);

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_mode |=> err_mode && !upd_valid && $stable(trap_lvl));

  p_forced_ps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_ret) |-> (upd_ps[4] && upd_ps[2] && !upd_ps[3] && !upd_ps[5] && !upd_ps[7]));

  p_both_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && trap_ready && ret_valid && trap_lvl < LVL_TOP) |=> !upd_ret);
endmodule

// File: tb/trap_entry_seq_tb.sv
module trap_entry_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int VA = 64;
  localparam int NWIN = 8;
  localparam int MAX_LVL = 5;
  localparam logic [63:0] BASE = 64'hDEAD_BEEF_1234_ABCD;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trap_valid = 1'b0, ret_valid = 1'b0;
  logic trap_ready;
  logic [8:0] trap_type = '0;
  logic [63:0] base_addr = BASE, cur_pc = '0, cur_npc = '0;
  logic [7:0] cur_cc = '0, cur_sid = '0;
  logic [9:0] cur_ps = '0;
  logic [2:0] cur_win = '0, save_avail = '0;
  logic upd_valid, upd_ret;
  logic [7:0] upd_cc, upd_sid;
  logic [9:0] upd_ps;
  logic [2:0] upd_win;
  logic [63:0] upd_pc, upd_npc;
  logic [2:0] trap_lvl;
  logic [8:0] saved_type;
  logic err_mode;
  logic [3:0] acc_addr_lo = '0;
  logic [2:0] acc_size = '0;
  logic misalign;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_entry_seq #(.VA(VA), .NWIN(NWIN), .MAX_LVL(MAX_LVL), .HAS_FPU(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .trap_valid(trap_valid), .trap_ready(trap_ready),
    .trap_type(trap_type), .base_addr(base_addr), .cur_pc(cur_pc), .cur_npc(cur_npc),
    .cur_cc(cur_cc), .cur_sid(cur_sid), .cur_ps(cur_ps), .cur_win(cur_win),
    .save_avail(save_avail), .ret_valid(ret_valid), .upd_valid(upd_valid),
    .upd_ret(upd_ret), .upd_cc(upd_cc), .upd_sid(upd_sid), .upd_ps(upd_ps),
    .upd_win(upd_win), .upd_pc(upd_pc), .upd_npc(upd_npc), .trap_lvl(trap_lvl),
    .saved_type(saved_type), .err_mode(err_mode), .acc_addr_lo(acc_addr_lo),
    .acc_size(acc_size), .misalign(misalign)
  );

  typedef struct packed {
    logic [8:0] tt;
    logic [2:0] win;
    logic [2:0] sav;
    logic [2:0] exp_win;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{9'h024, 3'd3, 3'd0, 3'd4},   // R4 clean
    '{9'h024, 3'd7, 3'd2, 3'd0},   // R4 wrap
    '{9'h080, 3'd2, 3'd1, 3'd5},   // R5 low end
    '{9'h0BF, 3'd6, 3'd3, 3'd3},   // R5 high end, wrap
    '{9'h0C0, 3'd0, 3'd4, 3'd7},   // R6 fill wrap
    '{9'h0FF, 3'd5, 3'd0, 3'd4},   // R6 high end
    '{9'h034, 3'd5, 3'd6, 3'd5},   // R6 other type
    '{9'h07F, 3'd1, 3'd7, 3'd1},   // R6 just below spill
    '{9'h100, 3'd2, 3'd3, 3'd2},   // R6 above fill
    '{9'h025, 3'd4, 3'd1, 3'd4}    // R6 just above clean
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp_v);
    end
  endtask

  function automatic logic [63:0] vec_of(input logic lnz, input logic [8:0] tt, input logic [4:0] lo);
    return {BASE[63:15], lnz, tt, lo};
  endfunction

  task automatic do_trap(input logic [8:0] tt, input logic [2:0] win, input logic [2:0] sav,
                         input logic [63:0] pc, input logic [9:0] ps, input logic with_ret);
    @(negedge clk);
    trap_valid = 1'b1; ret_valid = with_ret;
    trap_type = tt; cur_win = win; save_avail = sav;
    cur_pc = pc; cur_npc = pc + 64'd4; cur_ps = ps;
    cur_cc = pc[7:0] ^ 8'h5A; cur_sid = pc[15:8];
    @(negedge clk);
    trap_valid = 1'b0; ret_valid = 1'b0;
  endtask

  task automatic do_ret();
    @(negedge clk);
    ret_valid = 1'b1;
    @(negedge clk);
    ret_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 level", 64'(trap_lvl), 64'd0);
    chk("R1 err", 64'(err_mode), 64'd0);
    chk("R1 upd_valid", 64'(upd_valid), 64'd0);
    chk("R1 ready", 64'(trap_ready), 64'd1);
    chk("R1 saved_type", 64'(saved_type), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: single entry then return
    for (int i = 0; i < 10; i++) begin
      logic [63:0] pc;
      pc = 64'h4000 + 64'(i) * 64'h130;
      do_trap(VECS[i].tt, VECS[i].win, VECS[i].sav, pc, 10'h2A8, 1'b0);
      chk("R2 level", 64'(trap_lvl), 64'd1);
      chk("R2 upd_valid", 64'(upd_valid), 64'd1);
      chk("R2 upd_ret", 64'(upd_ret), 64'd0);
      chk("R2 cc", 64'(upd_cc), 64'(pc[7:0] ^ 8'h5A));
      chk("R3 ps", 64'(upd_ps), 64'h254);
      chk("R4/R5/R6 win", 64'(upd_win), 64'(VECS[i].exp_win));
      chk("R7 pc", upd_pc, vec_of(1'b0, VECS[i].tt, 5'b00000));
      chk("R7 npc", upd_npc, vec_of(1'b0, VECS[i].tt, 5'b00100));
      chk("R8 type", 64'(saved_type), 64'(VECS[i].tt));
      do_ret();
      chk("R9 ret flag", 64'(upd_ret), 64'd1);
      chk("R9 win", 64'(upd_win), 64'(VECS[i].win));
      chk("R9 pc", upd_pc, pc);
      chk("R9 npc", upd_npc, pc + 64'd4);
      chk("R9 ps", 64'(upd_ps), 64'h2A8);
      chk("R9 level", 64'(trap_lvl), 64'd0);
    end

    // R3 with trap little-endian set and memory model zero
    do_trap(9'h011, 3'd0, 3'd0, 64'h800, 10'h001, 1'b0);
    chk("R3 ps le", 64'(upd_ps), 64'h057);
    do_ret();

    // R9 return at level 0 ignored
    do_ret();
    chk("R9 idle ret valid", 64'(upd_valid), 64'd0);
    chk("R9 idle ret level", 64'(trap_lvl), 64'd0);

    // nest to the maximum level
    for (int k = 0; k < MAX_LVL; k++) begin
      do_trap(9'h040 + 9'(k), 3'(k), 3'd0, 64'h1000 * 64'(k + 1), 10'h000, 1'b0);
      chk("R2 nest level", 64'(trap_lvl), 64'(k + 1));
      chk("R7 nest pc", upd_pc, vec_of(k != 0, 9'h040 + 9'(k), 5'b00000));
      chk("R8 nest type", 64'(saved_type), 64'(9'h040 + 9'(k)));
    end
    for (int k = MAX_LVL - 1; k >= 0; k--) begin
      do_ret();
      chk("R9 unwind pc", upd_pc, 64'h1000 * 64'(k + 1));
      chk("R9 unwind win", 64'(upd_win), 64'(k));
      chk("R9 unwind level", 64'(trap_lvl), 64'(k));
      if (k > 0) chk("R8 unwind type", 64'(saved_type), 64'(9'h040 + 9'(k - 1)));
    end

    // R11 trap and return together
    do_trap(9'h050, 3'd1, 3'd0, 64'hA000, 10'h000, 1'b0);
    do_trap(9'h051, 3'd2, 3'd0, 64'hB000, 10'h000, 1'b1);
    chk("R11 level", 64'(trap_lvl), 64'd2);
    chk("R11 kind", 64'(upd_ret), 64'd0);
    chk("R11 pc", upd_pc, vec_of(1'b1, 9'h051, 5'b00000));
    do_reset();
    chk("R1 level after reset", 64'(trap_lvl), 64'd0);

    // R10 overflow into error mode
    for (int k = 0; k < MAX_LVL; k++)
      do_trap(9'h060 + 9'(k), 3'd0, 3'd0, 64'h2000 + 64'(k), 10'h000, 1'b0);
    chk("R10 full level", 64'(trap_lvl), 64'(MAX_LVL));
    do_trap(9'h070, 3'd0, 3'd0, 64'h3000, 10'h000, 1'b0);
    chk("R10 err", 64'(err_mode), 64'd1);
    chk("R10 no update", 64'(upd_valid), 64'd0);
    chk("R10 level held", 64'(trap_lvl), 64'(MAX_LVL));
    chk("R10 ready low", 64'(trap_ready), 64'd0);
    chk("R10 type kept", 64'(saved_type), 64'h064);
    do_ret();
    chk("R10 ret ignored valid", 64'(upd_valid), 64'd0);
    chk("R10 ret ignored level", 64'(trap_lvl), 64'(MAX_LVL));
    do_reset();
    chk("R1 err cleared", 64'(err_mode), 64'd0);

    // R12 alignment
    acc_size = 3'd2; acc_addr_lo = 4'h4; #1;
    chk("R12 word ok", 64'(misalign), 64'd0);
    acc_addr_lo = 4'h6; #1;
    chk("R12 word bad", 64'(misalign), 64'd1);
    acc_size = 3'd4; acc_addr_lo = 4'h8; #1;
    chk("R12 quad bad", 64'(misalign), 64'd1);
    acc_size = 3'd0; acc_addr_lo = 4'hF; #1;
    chk("R12 byte ok", 64'(misalign), 64'd0);
    acc_size = 3'd1; acc_addr_lo = 4'h1; #1;
    chk("R12 half bad", 64'(misalign), 64'd1);
    acc_size = 3'd3; acc_addr_lo = 4'h8; #1;
    chk("R12 dword ok", 64'(misalign), 64'd0);
    acc_size = 3'd6; acc_addr_lo = 4'h4; #1;
    chk("R12 code6 as quad", 64'(misalign), 64'd1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule